// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block decides which of 32 port pins, grouped as four ports of eight, carries each signal of the on-chip digital peripherals. Peripherals are visited in a fixed priority order. Each enabled one takes the next usable pins, counting upward from pin 0 of port 0. A pin is unusable when it is marked as an analog input, or when an external memory interface placed on the low ports claims it. The result is a per-pin map that a port controller consumes: a used flag, the global index of the signal on that pin, and a flag that tells the controller to turn that pin's output driver off.

The allocation runs as a sequential scan. The block samples the configuration it sees: the enable vector, the analog mask and the two memory-interface mode bits. When any of them differs from the copy it holds, it takes a new copy, clears the map and restarts from pin 0.0. It then places one signal per clock. `map_valid` is low while a scan is in progress. The outputs are plain levels with no handshake and no back-pressure. A consumer must ignore the map while `map_valid` is low.

Top module: `xbar_alloc`

## Requirements
- R1: Pins are filled in ascending index order (port × 8 + bit). No usable pin is left free below a pin that carries a signal.
- R2: Signals are placed in ascending global index, which encodes the priority. The enable bit and the signal indices for each peripheral are: bit 0 first UART (0 tx, 1 rx); bit 1 two-wire bus (2 data, 3 clock); bit 2 SPI (4 clock, 5 master-in, 6 master-out, 7 select); bit 3 second UART (8 tx, 9 rx); bit 4 capture/compare (10 to 14); bit 5 timer A external clock (15); bit 6 timer B external clock (16); bit 7 interrupt A (17); bit 8 interrupt B (18); bit 9 conversion start (19).
- R3: A peripheral whose enable bit is 0 occupies no pin. When every enable bit is 0, no pin is used.
- R4: An enabled peripheral places all of its signals. When no pin is skipped between them, they land on consecutive pins.
- R5: A pin whose bit is set in `analog_mask` is never used. Allocation continues on the next usable pin.
- R6: With `emif_low` set, pins 6 and 7 are never used. With `emif_mux` also set, pin 5 is never used either. `emif_mux` has no effect while `emif_low` is 0.
- R7: `pin_in` is 1 exactly on used pins that carry an input signal. Input signals are indices 1, 5, 7, 9 and 15 to 19.
- R8: If the enabled signals outnumber the usable pins, the signals that do not fit are left unplaced and `overflow` is 1. When `overflow` is 1, every usable pin is used.
- R9: Any change of the configuration inputs drops `map_valid` at the next edge and restarts allocation. `map_valid` returns within NUM_SIGS+1 cycles of the edge that saw the change, where NUM_SIGS is the total number of peripheral signals (20 by default). The final map depends only on the last configuration.
- R10: Reset clears `pin_used`, `pin_sig`, `pin_in`, `overflow` and `map_valid`.
- R11: A pin that is not used reports signal index 0 and `pin_in` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_en | input | 10 | Per-peripheral enable, bit order as in R2 |
| analog_mask | input | 32 | 1 marks a pin as analog input, so it is skipped |
| emif_low | input | 1 | Memory interface sits on the low ports, which reserves pins 6 and 7 |
| emif_mux | input | 1 | Memory interface is multiplexed, which also reserves pin 5 |
| pin_used | output | 32 | 1 where a peripheral signal occupies the pin |
| pin_sig | output | 160 | Five-bit global signal index per pin, pin n in bits 5n+4..5n |
| pin_in | output | 32 | 1 where the pin carries an input, so its driver must be off |
| overflow | output | 1 | Some enabled signal found no pin |
| map_valid | output | 1 | Map is complete for the current configuration |

## Verification
On every cycle, the bound checker checks several things. Skipped pins and reserved memory-interface pins stay unused in a valid map. Input flags appear only on used pins. An overflow implies that every usable pin is full. A configuration change drops the valid flag, and the scan finishes within its cycle bound. Only the bench scenarios can show which signal lands on which pin. These cover priority order, group placement, the mixed skip case, disabled peripherals, a change in the middle of a scan and the exact overflow cut-off. Each scenario compares the full map against a model built from the requirements.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int NUM_PERIPH = 10;
  localparam int CC_CH      = 5;
  localparam int NUM_SIGS   = 15 + CC_CH;
  localparam int SIG_W      = $clog2(NUM_SIGS);
  localparam int PER_W      = $clog2(NUM_PERIPH);

  // Priority order equals enum order.
  typedef enum logic [PER_W-1:0] {
    PR_UART_A = 0,
    PR_TWI    = 1,
    PR_SPI    = 2,
    PR_UART_B = 3,
    PR_CCAP   = 4,
    PR_TMR_A  = 5,
    PR_TMR_B  = 6,
    PR_IRQ_A  = 7,
    PR_IRQ_B  = 8,
    PR_CNV    = 9
  } periph_e;

  function automatic int unsigned periph_sigs(input int unsigned p);
    case (p)
      0, 1, 3: return 2;
      2:       return 4;
      4:       return CC_CH;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned periph_base(input int unsigned p);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < p; k++) acc += periph_sigs(k);
    return acc;
  endfunction

  function automatic int unsigned owner_of(input int unsigned s);
    int unsigned own;
    own = 0;
    for (int unsigned k = 0; k < NUM_PERIPH; k++)
      if (s >= periph_base(k)) own = k;
    return own;
  endfunction

  function automatic logic sig_dir_in(input int unsigned s);
    int unsigned own;
    int unsigned off;
    own = owner_of(s);
    off = s - periph_base(own);
    case (own)
      0, 3:    return (off == 1);
      1, 4:    return 1'b0;
      2:       return (off == 1) || (off == 3);
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/xbar_sig_table.sv
module xbar_sig_table
  import xbar_pkg::*;
(
  input  logic [SIG_W-1:0] sig_idx,
  output logic [PER_W-1:0] owner,
  output logic             is_in
);

  logic [NUM_SIGS-1:0][PER_W-1:0] tbl_owner;
  logic [NUM_SIGS-1:0]            tbl_in;

  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_row
    assign tbl_owner[s] = PER_W'(owner_of(s));
    assign tbl_in[s]    = sig_dir_in(s);
  end

  always_comb begin
    owner = '0;
    is_in = 1'b0;
    if (int'(sig_idx) < NUM_SIGS) begin
      owner = tbl_owner[sig_idx];
      is_in = tbl_in[sig_idx];
    end
  end

endmodule

// File: rtl/xbar_skip_gen.sv
module xbar_skip_gen #(
  parameter int NUM_PINS = 32,
  parameter int ALE_PIN  = 5,
  parameter int RD_PIN   = 6,
  parameter int WR_PIN   = 7
) (
  input  logic [NUM_PINS-1:0] analog_mask,
  input  logic                emif_low,
  input  logic                emif_mux,
  output logic [NUM_PINS-1:0] usable
);

  logic [NUM_PINS-1:0] reserved;

  always_comb begin
    reserved = '0;
    if (emif_low) begin
      reserved[RD_PIN] = 1'b1;
      reserved[WR_PIN] = 1'b1;
      if (emif_mux) reserved[ALE_PIN] = 1'b1;
    end
  end

  assign usable = ~(analog_mask | reserved);

endmodule

// File: rtl/xbar_pin_seek.sv
module xbar_pin_seek #(
  parameter int NUM_PINS = 32,
  parameter int PTR_W    = 6,
  parameter int PIN_W    = 5
) (
  input  logic [NUM_PINS-1:0] usable,
  input  logic [PTR_W-1:0]    start,
  output logic                found,
  output logic [PIN_W-1:0]    pin
);

  // Lowest usable pin at or above start.
  always_comb begin
    found = 1'b0;
    pin   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (usable[i] && (PTR_W'(i) >= start)) begin
        found = 1'b1;
        pin   = PIN_W'(i);
      end
    end
  end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int PORTS  = 4,
  parameter int PORT_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PERIPH-1:0]          periph_en,
  input  logic [PORTS*PORT_W-1:0]        analog_mask,
  input  logic                           emif_low,
  input  logic                           emif_mux,
  output logic [PORTS*PORT_W-1:0]        pin_used,
  output logic [PORTS*PORT_W*SIG_W-1:0]  pin_sig,
  output logic [PORTS*PORT_W-1:0]        pin_in,
  output logic                           overflow,
  output logic                           map_valid
);

  localparam int NUM_PINS = PORTS * PORT_W;
  localparam int PTR_W    = $clog2(NUM_PINS + 1);
  localparam int PIN_W    = $clog2(NUM_PINS);
  localparam int CNT_W    = $clog2(NUM_SIGS + 1);

  typedef struct packed {
    logic [NUM_PERIPH-1:0] en;
    logic [NUM_PINS-1:0]   analog;
    logic                  low;
    logic                  mux;
  } cfg_t;

  cfg_t live_cfg, snap_cfg;
  assign live_cfg = '{en: periph_en, analog: analog_mask, low: emif_low, mux: emif_mux};

  logic                            busy;
  logic [CNT_W-1:0]                sig_cnt;
  logic [PTR_W-1:0]                next_pin;
  logic [NUM_PINS-1:0]             used_q, in_q;
  logic [NUM_PINS-1:0][SIG_W-1:0]  sig_q;
  logic                            ovf_q, valid_q;

  logic [NUM_PINS-1:0] usable;
  logic [PER_W-1:0]    cur_owner;
  logic                cur_in;
  logic                seek_found;
  logic [PIN_W-1:0]    seek_pin;
  logic                cfg_changed;
  logic                scan_done;

  xbar_skip_gen #(.NUM_PINS(NUM_PINS)) u_skip (
    .analog_mask (snap_cfg.analog),
    .emif_low    (snap_cfg.low),
    .emif_mux    (snap_cfg.mux),
    .usable      (usable)
  );

  xbar_sig_table u_table (
    .sig_idx (sig_cnt[SIG_W-1:0]),
    .owner   (cur_owner),
    .is_in   (cur_in)
  );

  xbar_pin_seek #(.NUM_PINS(NUM_PINS), .PTR_W(PTR_W), .PIN_W(PIN_W)) u_seek (
    .usable (usable),
    .start  (next_pin),
    .found  (seek_found),
    .pin    (seek_pin)
  );

  assign cfg_changed = (live_cfg != snap_cfg);
  assign scan_done   = (int'(sig_cnt) == NUM_SIGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cfg <= '0;
      busy     <= 1'b1;
      sig_cnt  <= '0;
      next_pin <= '0;
      used_q   <= '0;
      in_q     <= '0;
      sig_q    <= '0;
      ovf_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else if (cfg_changed) begin
      snap_cfg <= live_cfg;
      busy     <= 1'b1;
      sig_cnt  <= '0;
      next_pin <= '0;
      used_q   <= '0;
      in_q     <= '0;
      sig_q    <= '0;
      ovf_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else if (busy) begin
      if (scan_done) begin
        busy    <= 1'b0;
        valid_q <= 1'b1;
      end else begin
        if (snap_cfg.en[cur_owner]) begin
          if (seek_found) begin
            used_q[seek_pin] <= 1'b1;
            in_q[seek_pin]   <= cur_in;
            sig_q[seek_pin]  <= sig_cnt[SIG_W-1:0];
            next_pin         <= PTR_W'(seek_pin) + 1'b1;
          end else begin
            ovf_q <= 1'b1;
          end
        end
        sig_cnt <= sig_cnt + 1'b1;
      end
    end
  end

  assign pin_used  = used_q;
  assign pin_in    = in_q;
  assign pin_sig   = sig_q;
  assign overflow  = ovf_q;
  assign map_valid = valid_q;

endmodule

// File: rtl/xbar_alloc_chk.sv
module xbar_alloc_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_PERIPH-1:0]     periph_en,
  input logic [NUM_PINS-1:0]       analog_mask,
  input logic                      emif_low,
  input logic                      emif_mux,
  input logic [NUM_PINS-1:0]       pin_used,
  input logic [NUM_PINS*SIG_W-1:0] pin_sig,
  input logic [NUM_PINS-1:0]       pin_in,
  input logic                      overflow,
  input logic                      map_valid
);

  localparam int CFG_W = NUM_PERIPH + NUM_PINS + 2;
  localparam int LAT   = NUM_SIGS + 1;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             chg;
  logic [7:0]       wait_cnt;
  logic [NUM_PINS-1:0] blocked;

  assign cfg_now = {periph_en, analog_mask, emif_low, emif_mux};
  assign chg     = (cfg_now != cfg_q);

  always_comb begin
    blocked = analog_mask;
    if (emif_low) begin
      blocked[6] = 1'b1;
      blocked[7] = 1'b1;
      if (emif_mux) blocked[5] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      wait_cnt <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (chg)             wait_cnt <= '0;
      else if (!map_valid) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assert_analog_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !chg) |-> ((pin_used & analog_mask) == '0));

  assert_emif_pins_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !chg && emif_low) |->
      (!pin_used[6] && !pin_used[7] && (!emif_mux || !pin_used[5])));

  assert_input_on_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_in & ~pin_used) == '0));

  assert_full_on_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !chg && overflow) |-> (&(pin_used | blocked)));

  assert_none_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !chg && (periph_en == '0)) |-> (pin_used == '0));

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !map_valid);

  assert_scan_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wait_cnt) <= LAT));

  assert_use_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pin_used) <= NUM_SIGS));

endmodule

bind xbar_alloc xbar_alloc_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .periph_en   (periph_en),
  .analog_mask (analog_mask),
  .emif_low    (emif_low),
  .emif_mux    (emif_mux),
  .pin_used    (pin_used),
  .pin_sig     (pin_sig),
  .pin_in      (pin_in),
  .overflow    (overflow),
  .map_valid   (map_valid)
);

// File: tb/xbar_alloc_bench.sv
`timescale 1ns/1ps
module xbar_alloc_bench;

  localparam int NP = 32;
  localparam int NS = 20;
  localparam int SW = 5;
  localparam int LAT_MAX = NS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    periph_en = '0;
  logic [NP-1:0] analog_mask = '0;
  logic          emif_low = 1'b0;
  logic          emif_mux = 1'b0;
  logic [NP-1:0]    pin_used;
  logic [NP*SW-1:0] pin_sig;
  logic [NP-1:0]    pin_in;
  logic             overflow;
  logic             map_valid;

  always #2.5 clk = ~clk;

  xbar_alloc u_xbar_alloc (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .analog_mask(analog_mask),
    .emif_low(emif_low), .emif_mux(emif_mux), .pin_used(pin_used),
    .pin_sig(pin_sig), .pin_in(pin_in), .overflow(overflow), .map_valid(map_valid)
  );

  typedef struct {
    logic [NP-1:0]    used;
    logic [NP*SW-1:0] sig;
    logic [NP-1:0]    inp;
    logic             ovf;
    string            req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int pushed = 0;
  int done_cnt = 0;
  bit finished = 0;

  // Signal counts per enable bit and input-signal set, as listed in R2 and R7.
  int cnt_tbl[10] = '{2, 2, 4, 2, 5, 1, 1, 1, 1, 1};
  localparam logic [NS-1:0] IN_SIGS = 20'b1111_1000_0010_1010_0010;

  task automatic chk(input string req, input string what, input logic [NP*SW-1:0] act,
                     input logic [NP*SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [9:0] en, input logic [NP-1:0] an,
                                 input logic lo, input logic mx, input string rq);
    exp_t e;
    int pin = 0;
    int s = 0;
    logic [NP-1:0] skip = an;
    e.used = '0; e.sig = '0; e.inp = '0; e.ovf = 1'b0; e.req = rq;
    if (lo) begin
      skip[6] = 1'b1; skip[7] = 1'b1;
      if (mx) skip[5] = 1'b1;
    end
    for (int p = 0; p < 10; p++) begin
      for (int k = 0; k < cnt_tbl[p]; k++) begin
        if (en[p]) begin
          while (pin < NP && skip[pin]) pin++;
          if (pin < NP) begin
            e.used[pin] = 1'b1;
            e.sig[pin*SW +: SW] = SW'(s);
            e.inp[pin] = IN_SIGS[s];
            pin++;
          end else begin
            e.ovf = 1'b1;
          end
        end
        s++;
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [9:0] en, input logic [NP-1:0] an,
                       input logic lo, input logic mx, input string rq);
    @(negedge clk);
    periph_en = en; analog_mask = an; emif_low = lo; emif_mux = mx;
    q.push_back(model(en, an, lo, mx, rq));
    pushed++;
    wait (done_cnt == pushed);
  endtask

  // Monitor: pops expected maps and compares once the scan completes.
  initial begin
    forever begin
      exp_t e;
      int n;
      wait (q.size() > 0);
      e = q.pop_front();
      @(posedge clk);
      n = 0;
      @(negedge clk);
      while (!map_valid && n < 60) begin
        n++;
        @(negedge clk);
      end
      chk({e.req, " R9"}, "latency", n, (n <= LAT_MAX) ? n : LAT_MAX);
      chk({e.req, " R1 R2"}, "pin_sig", pin_sig, e.sig);
      chk({e.req, " R3 R4 R5"}, "pin_used", pin_used, e.used);
      chk({e.req, " R7 R11"}, "pin_in", pin_in, e.inp);
      chk({e.req, " R8"}, "overflow", overflow, e.ovf);
      done_cnt++;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset used", pin_used, '0);
    chk("R10", "reset sig", pin_sig, '0);
    chk("R10", "reset valid/ovf/in", {map_valid, overflow, pin_in}, '0);
    rst_n = 1'b1;
    q.push_back(model('0, '0, 1'b0, 1'b0, "R3 R10"));
    pushed++;
    wait (done_cnt == pushed);

    // Mixed case: bus, both UARTs, both interrupts, multiplexed low interface, analog 1.2-1.4
    drive(10'b01_1000_1011, 32'h0000_1C00, 1'b1, 1'b1, "R5 R6");
    // Everything enabled, nothing skipped: consecutive fill
    drive(10'h3FF, '0, 1'b0, 1'b0, "R2 R4");
    // SPI, second UART, conversion start with non-multiplexed interface
    drive(10'b10_0000_1100, '0, 1'b1, 1'b0, "R4 R6 R7");
    // Multiplexed bit without the low placement has no effect
    drive(10'b00_0000_0101, '0, 1'b0, 1'b1, "R6");
    // Only interrupt B enabled
    drive(10'b01_0000_0000, '0, 1'b0, 1'b0, "R3");
    // Too few usable pins
    drive(10'h3FF, 32'hFFFF_0000, 1'b0, 1'b0, "R8");
    // Change in the middle of a scan: only the final configuration counts
    @(negedge clk);
    periph_en = 10'h3FF; analog_mask = '0; emif_low = 1'b1; emif_mux = 1'b1;
    repeat (3) @(negedge clk);
    drive(10'b00_1000_0001, 32'h0000_00F0, 1'b0, 1'b0, "R9");
    // Reconfigure once more with heavy analog skipping on port 0
    drive(10'b00_0000_1111, 32'h0000_03FE, 1'b1, 1'b1, "R1 R5");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule